// File: doc/BRIEF.md
# Block Transfer Command Splitter

This block takes one block-level read or write request and turns it into a series of device commands. Each command covers a bounded number of 512-byte sectors. A request carries a 48-bit start block, a block count, a buffer address, a direction flag and an addressing-mode flag. For every chunk, the block presents a command record on a valid/ready output. The record holds the opcode, six address bytes, a device byte and two sector-count bytes, together with the chunk's byte length and buffer address.

After a command is accepted, the block waits for a one-cycle done pulse from the executing engine before it builds the next chunk. A chunk never holds more than 127 sectors, so its byte length stays below 64 KB and fits one transfer descriptor.

When the last chunk is acknowledged, the block raises a one-cycle completion pulse and reports the total block count of the original request. It then accepts a new request.

Top module: `blk_cmd_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, cmd_valid_o is 0 and done_o is 0.
- R2: Each chunk carries min(remaining blocks, 127) sectors, and cmd_len_o equals that count times 512.
- R3: Chunks go out in ascending order. Each chunk's start block and buffer address exceed the previous chunk's by its sector count and by 512 bytes per sector respectively.
- R4: In 48-bit mode (req_lba48_i=1), the opcode is 0x25 for read and 0x35 for write. Address bytes 0..5 of the block appear on cmd_lba_lo/mid/hi and then cmd_lba_lo_ext/mid_ext/hi_ext. The count's low byte is on cmd_cnt_lo_o and its high byte is on cmd_cnt_hi_o.
- R5: In 28-bit mode, the opcode is 0x20 for read and 0x30 for write. Block bits [23:0] fill the three low address bytes, and bits [27:24] go to device-byte bits [3:0]. The extended address bytes and cmd_cnt_hi_o are 0.
- R6: Bit 6 (0x40) of cmd_dev_o is set on every command.
- R7: While cmd_valid_o=1 and cmd_ready_i=0, the command record stays unchanged. After acceptance, no further command is presented until chunk_done_i pulses.
- R8: done_o pulses for exactly one cycle, in the cycle after the chunk_done_i that closes the last chunk. In that cycle, done_count_o equals the original block count.
- R9: A request with a block count of 0 emits no command, and done_o pulses in the cycle after acceptance with done_count_o=0.
- R10: While a request is in progress, req_ready_o is 0 and req_valid_i is ignored. The running transfer keeps its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken on valid |
| req_lba_i | input | 48 | Start block |
| req_count_i | input | CNT_W (16) | Number of blocks |
| req_buf_i | input | ADDR_W (32) | Buffer byte address |
| req_write_i | input | 1 | 1 write, 0 read |
| req_lba48_i | input | 1 | 1 for 48-bit addressing, 0 for 28-bit |
| cmd_valid_o | output | 1 | Command record valid |
| cmd_ready_i | input | 1 | Command record accepted |
| cmd_code_o | output | 8 | Opcode |
| cmd_lba_lo_o | output | 8 | Address byte 0 |
| cmd_lba_mid_o | output | 8 | Address byte 1 |
| cmd_lba_hi_o | output | 8 | Address byte 2 |
| cmd_lba_lo_ext_o | output | 8 | Address byte 3 (48-bit only) |
| cmd_lba_mid_ext_o | output | 8 | Address byte 4 (48-bit only) |
| cmd_lba_hi_ext_o | output | 8 | Address byte 5 (48-bit only) |
| cmd_dev_o | output | 8 | Device byte |
| cmd_cnt_lo_o | output | 8 | Sector count low byte |
| cmd_cnt_hi_o | output | 8 | Sector count high byte |
| cmd_len_o | output | LEN_W (16) | Chunk length in bytes |
| cmd_buf_o | output | ADDR_W (32) | Chunk buffer address |
| chunk_done_i | input | 1 | Pulse when the accepted chunk has finished |
| done_o | output | 1 | One-cycle completion pulse |
| done_count_o | output | CNT_W (16) | Total block count, valid with done_o |

## Verification
The bench targets the chunk boundary: counts of exactly 127, 128 and 300 blocks. A design that splits wrongly would emit a 128-sector chunk, an empty trailing chunk, or drop the remainder. It uses a 28-bit address with nonzero bits [27:24] and a 48-bit address with all six bytes distinct. These expose swapped or missing address bytes, a device nibble that is not filled in, and stray extended bytes in 28-bit mode. It also holds off cmd_ready_i, injects a request mid-transfer and issues a zero-count request. A faulty design would change the record before acceptance, issue the next chunk before the done pulse, take the stray request, or hang or emit a command for zero blocks.

// File: rtl/blk_split_pkg.sv
package blk_split_pkg;
  localparam logic [7:0] OP_RD28 = 8'h20;
  localparam logic [7:0] OP_WR28 = 8'h30;
  localparam logic [7:0] OP_RD48 = 8'h25;
  localparam logic [7:0] OP_WR48 = 8'h35;
  localparam logic [7:0] DEV_LBA_BIT = 8'h40;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} split_state_e;

  typedef struct packed {
    logic [7:0]      code;
    logic [7:0]      dev;
    logic [7:0]      cnt_hi;
    logic [7:0]      cnt_lo;
    logic [5:0][7:0] lba;
  } cmd_rec_t;
endpackage

// File: rtl/blk_chunk_sizer.sv
module blk_chunk_sizer #(
  parameter int CNT_W    = 16,
  parameter int MAX_SECT = 127,
  parameter int CHUNK_W  = 7
) (
  input  logic [CNT_W-1:0]   remain_i,
  output logic [CHUNK_W-1:0] chunk_o,
  output logic               last_o
);
  always_comb begin
    last_o  = (remain_i <= CNT_W'(MAX_SECT));
    chunk_o = last_o ? CHUNK_W'(remain_i) : CHUNK_W'(MAX_SECT);
  end
endmodule

// File: rtl/blk_cmd_encode.sv
module blk_cmd_encode
  import blk_split_pkg::*;
#(
  parameter int CHUNK_W = 7
) (
  input  logic [47:0]        lba_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic               write_i,
  input  logic               lba48_i,
  output cmd_rec_t           rec_o
);
  logic [15:0] cnt16;
  assign cnt16 = 16'(chunk_i);

  // low three bytes always; upper three only in 48-bit mode
  for (genvar k = 0; k < 6; k++) begin : g_addr
    if (k < 3) begin : g_low
      assign rec_o.lba[k] = lba_i[8*k +: 8];
    end else begin : g_ext
      assign rec_o.lba[k] = lba48_i ? lba_i[8*k +: 8] : 8'h00;
    end
  end

  always_comb begin
    if (lba48_i) begin
      rec_o.code   = write_i ? OP_WR48 : OP_RD48;
      rec_o.dev    = DEV_LBA_BIT;
      rec_o.cnt_hi = cnt16[15:8];
    end else begin
      rec_o.code   = write_i ? OP_WR28 : OP_RD28;
      rec_o.dev    = DEV_LBA_BIT | {4'h0, lba_i[27:24]};
      rec_o.cnt_hi = 8'h00;
    end
    rec_o.cnt_lo = cnt16[7:0];
  end
endmodule

// File: rtl/blk_split_ctrl.sv
module blk_split_ctrl
  import blk_split_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CHUNK_W = 7,
  parameter int LEN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [47:0]        req_lba_i,
  input  logic [CNT_W-1:0]   req_count_i,
  input  logic [ADDR_W-1:0]  req_buf_i,
  input  logic               req_write_i,
  input  logic               req_lba48_i,
  input  logic               cmd_ready_i,
  input  logic               chunk_done_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic [LEN_W-1:0]   chunk_len_i,
  input  logic               last_i,
  output logic               issue_o,
  output logic               fin_o,
  output logic [47:0]        lba_o,
  output logic [ADDR_W-1:0]  buf_o,
  output logic [CNT_W-1:0]   remain_o,
  output logic [CNT_W-1:0]   total_o,
  output logic               write_o,
  output logic               lba48_o
);
  split_state_e state_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign issue_o     = (state_q == ST_ISSUE);
  assign fin_o       = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lba_o    <= '0;
      buf_o    <= '0;
      remain_o <= '0;
      total_o  <= '0;
      write_o  <= 1'b0;
      lba48_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          lba_o    <= req_lba_i;
          buf_o    <= req_buf_i;
          remain_o <= req_count_i;
          total_o  <= req_count_i;
          write_o  <= req_write_i;
          lba48_o  <= req_lba48_i;
          state_q  <= (req_count_i == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: if (cmd_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (chunk_done_i) begin
          lba_o    <= lba_o + 48'(chunk_i);
          buf_o    <= buf_o + ADDR_W'(chunk_len_i);
          remain_o <= remain_o - CNT_W'(chunk_i);
          state_q  <= last_i ? ST_FIN : ST_ISSUE;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_cmd_splitter.sv
module blk_cmd_splitter
  import blk_split_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int SECT_BYTES  = 512,
  parameter int XFER_LIMIT  = 65536,
  localparam int MAX_SECT   = (XFER_LIMIT - 1) / SECT_BYTES,
  localparam int CHUNK_W    = $clog2(MAX_SECT + 1),
  localparam int LEN_W      = $clog2(XFER_LIMIT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [47:0]       req_lba_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [ADDR_W-1:0] req_buf_i,
  input  logic              req_write_i,
  input  logic              req_lba48_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [7:0]        cmd_code_o,
  output logic [7:0]        cmd_lba_lo_o,
  output logic [7:0]        cmd_lba_mid_o,
  output logic [7:0]        cmd_lba_hi_o,
  output logic [7:0]        cmd_lba_lo_ext_o,
  output logic [7:0]        cmd_lba_mid_ext_o,
  output logic [7:0]        cmd_lba_hi_ext_o,
  output logic [7:0]        cmd_dev_o,
  output logic [7:0]        cmd_cnt_lo_o,
  output logic [7:0]        cmd_cnt_hi_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [ADDR_W-1:0] cmd_buf_o,
  input  logic              chunk_done_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  done_count_o
);
  logic [CHUNK_W-1:0] chunk;
  logic               last;
  logic [LEN_W-1:0]   chunk_len;
  logic [47:0]        cur_lba;
  logic [CNT_W-1:0]   remain, total;
  logic               cur_wr, cur_l48;
  cmd_rec_t           rec;

  assign chunk_len = LEN_W'(chunk) * LEN_W'(SECT_BYTES);

  blk_chunk_sizer #(.CNT_W(CNT_W), .MAX_SECT(MAX_SECT), .CHUNK_W(CHUNK_W)) u_sizer (
    .remain_i(remain), .chunk_o(chunk), .last_o(last)
  );

  blk_split_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CHUNK_W(CHUNK_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_lba_i, .req_count_i,
    .req_buf_i, .req_write_i, .req_lba48_i, .cmd_ready_i, .chunk_done_i,
    .chunk_i(chunk), .chunk_len_i(chunk_len), .last_i(last),
    .issue_o(cmd_valid_o), .fin_o(done_o), .lba_o(cur_lba), .buf_o(cmd_buf_o),
    .remain_o(remain), .total_o(total), .write_o(cur_wr), .lba48_o(cur_l48)
  );

  blk_cmd_encode #(.CHUNK_W(CHUNK_W)) u_enc (
    .lba_i(cur_lba), .chunk_i(chunk), .write_i(cur_wr), .lba48_i(cur_l48), .rec_o(rec)
  );

  assign cmd_code_o        = rec.code;
  assign cmd_dev_o         = rec.dev;
  assign cmd_cnt_lo_o      = rec.cnt_lo;
  assign cmd_cnt_hi_o      = rec.cnt_hi;
  assign cmd_lba_lo_o      = rec.lba[0];
  assign cmd_lba_mid_o     = rec.lba[1];
  assign cmd_lba_hi_o      = rec.lba[2];
  assign cmd_lba_lo_ext_o  = rec.lba[3];
  assign cmd_lba_mid_ext_o = rec.lba[4];
  assign cmd_lba_hi_ext_o  = rec.lba[5];
  assign cmd_len_o         = chunk_len;
  assign done_count_o      = total;
endmodule

// File: rtl/blk_cmd_splitter_chk.sv
module blk_cmd_splitter_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16,
  parameter int MAX_LEN = 65024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [7:0]        cmd_code_o,
  input logic [7:0]        cmd_lba_lo_ext_o,
  input logic [7:0]        cmd_lba_mid_ext_o,
  input logic [7:0]        cmd_lba_hi_ext_o,
  input logic [7:0]        cmd_dev_o,
  input logic [7:0]        cmd_cnt_hi_o,
  input logic [LEN_W-1:0]  cmd_len_o,
  input logic [ADDR_W-1:0] cmd_buf_o,
  input logic              done_o
);
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o != '0 && 32'(cmd_len_o) <= MAX_LEN)); // R2
  AST_DEV_LBA_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_dev_o[6]); // R6
  AST_SHORT_NO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_code_o == 8'h20 || cmd_code_o == 8'h30)) |->
      (cmd_lba_lo_ext_o == 8'h0 && cmd_lba_mid_ext_o == 8'h0 &&
       cmd_lba_hi_ext_o == 8'h0 && cmd_cnt_hi_o == 8'h0)); // R5
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_len_o) && $stable(cmd_buf_o))); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i) |=> !cmd_valid_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || done_o) |-> !req_ready_o); // R10
endmodule

bind blk_cmd_splitter blk_cmd_splitter_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_SECT * SECT_BYTES)
) u_chk (.*);

// File: tb/sim_blk_cmd_splitter.sv
module sim_blk_cmd_splitter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_l48 = 0;
  logic [47:0] req_lba = '0;
  logic [15:0] req_count = '0;
  logic [31:0] req_buf = '0;
  logic        cmd_ready = 0, chunk_done = 0;
  logic        req_ready, cmd_valid, done;
  logic [7:0]  code, b0, b1, b2, b3, b4, b5, dev, cnt_lo, cnt_hi;
  logic [15:0] len, done_cnt;
  logic [31:0] cbuf;

  int n_chk = 0;
  int n_fail = 0;

  blk_cmd_splitter u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_lba_i(req_lba), .req_count_i(req_count), .req_buf_i(req_buf),
    .req_write_i(req_write), .req_lba48_i(req_l48), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_code_o(code), .cmd_lba_lo_o(b0), .cmd_lba_mid_o(b1),
    .cmd_lba_hi_o(b2), .cmd_lba_lo_ext_o(b3), .cmd_lba_mid_ext_o(b4),
    .cmd_lba_hi_ext_o(b5), .cmd_dev_o(dev), .cmd_cnt_lo_o(cnt_lo), .cmd_cnt_hi_o(cnt_hi),
    .cmd_len_o(len), .cmd_buf_o(cbuf), .chunk_done_i(chunk_done), .done_o(done),
    .done_count_o(done_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_fields(input logic [47:0] lba, input int n, input logic [31:0] bptr,
                            input bit wr, input bit l48);
    logic [7:0] e_code, e_dev;
    logic [47:0] e_addr, a_addr;
    e_code = l48 ? (wr ? 8'h35 : 8'h25) : (wr ? 8'h30 : 8'h20);
    e_dev  = l48 ? 8'h40 : (8'h40 | {4'h0, lba[27:24]});
    e_addr = l48 ? lba : {24'h0, lba[23:0]};
    a_addr = {b5, b4, b3, b2, b1, b0};
    chk(cmd_valid == 1'b1, "R7 cmd_valid", 64'(cmd_valid), 1);
    chk(code == e_code, l48 ? "R4 opcode" : "R5 opcode", 64'(code), 64'(e_code));
    chk(a_addr == e_addr, l48 ? "R4 address" : "R5 address", 64'(a_addr), 64'(e_addr));
    chk(dev == e_dev, "R6 device", 64'(dev), 64'(e_dev));
    chk(cnt_lo == 8'(n) && cnt_hi == 8'h0, "R2 count bytes", 64'({cnt_hi, cnt_lo}), 64'(n));
    chk(len == 16'(n * 512), "R2 length", 64'(len), 64'(n * 512));
    chk(cbuf == bptr, "R3 buffer", 64'(cbuf), 64'(bptr));
  endtask

  task automatic send_req(input logic [47:0] lba, input logic [15:0] cnt,
                          input logic [31:0] bptr, input bit wr, input bit l48);
    chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 1);
    req_valid = 1; req_lba = lba; req_count = cnt; req_buf = bptr;
    req_write = wr; req_l48 = l48;
    step();
    req_valid = 0;
  endtask

  task automatic run_xfer(input logic [47:0] lba, input logic [15:0] cnt, input logic [31:0] bptr,
                          input bit wr, input bit l48, input int hold, input int gap, input bit stray);
    logic [47:0] cl;
    logic [31:0] cb;
    int rem, n;
    send_req(lba, cnt, bptr, wr, l48);
    cl = lba; cb = bptr; rem = int'(cnt);
    if (rem == 0) begin
      chk(done == 1'b1 && cmd_valid == 1'b0, "R9 zero count done", 64'({done, cmd_valid}), 64'h2);
      chk(done_cnt == 16'h0, "R9 zero total", 64'(done_cnt), 0);
      step();
      chk(done == 1'b0 && req_ready == 1'b1, "R8 done pulse width", 64'({done, req_ready}), 64'h1);
      return;
    end
    while (rem > 0) begin
      n = (rem > 127) ? 127 : rem;
      for (int h = 0; h < hold; h++) begin
        chk_fields(cl, n, cb, wr, l48);
        step();
      end
      chk_fields(cl, n, cb, wr, l48);
      cmd_ready = 1;
      step();
      cmd_ready = 0;
      for (int g = 0; g < gap; g++) begin
        chk(cmd_valid == 1'b0, "R7 no command before chunk done", 64'(cmd_valid), 0);
        chk(req_ready == 1'b0, "R10 busy ready low", 64'(req_ready), 0);
        if (stray) begin
          req_valid = 1; req_lba = 48'hFFFF_FFFF_FFFF; req_count = 16'd5;
          req_buf = 32'hDEAD_0000; req_write = ~wr; req_l48 = ~l48;
        end
        step();
        req_valid = 0;
      end
      chunk_done = 1;
      step();
      chunk_done = 0;
      rem -= n; cl += 48'(n); cb += 32'(n * 512);
      if (rem == 0) begin
        chk(done == 1'b1 && cmd_valid == 1'b0, "R8 done after last chunk", 64'({done, cmd_valid}), 64'h2);
        chk(done_cnt == cnt, "R8 total count", 64'(done_cnt), 64'(cnt));
        step();
        chk(done == 1'b0 && req_ready == 1'b1, "R8 done one cycle", 64'({done, req_ready}), 64'h1);
      end
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1 reset cmd_valid", 64'(cmd_valid), 0);
    chk(done == 1'b0, "R1 reset done", 64'(done), 0);
  endtask

  task automatic t_lba48_three_chunks();  // R2 R3 R4
    run_xfer(48'h0000_0010_0000, 16'd300, 32'h1000_0000, 1'b0, 1'b1, 0, 2, 1'b0);
  endtask

  task automatic t_lba28_exact_limit();  // R5 R6
    run_xfer(48'h0000_0A12_3456, 16'd127, 32'h0000_4000, 1'b1, 1'b0, 0, 1, 1'b0);
  endtask

  task automatic t_lba28_one_over();  // R2 R5
    run_xfer(48'h0000_05FF_FFC0, 16'd128, 32'h0002_0000, 1'b0, 1'b0, 0, 1, 1'b0);
  endtask

  task automatic t_lba48_wide_addr_hold();  // R4 R7
    run_xfer(48'hC1B2_A394_8576, 16'd1, 32'h8000_0200, 1'b1, 1'b1, 3, 0, 1'b0);
  endtask

  task automatic t_stray_request();  // R10
    run_xfer(48'h0000_0000_0100, 16'd200, 32'h0000_0000, 1'b1, 1'b1, 1, 2, 1'b1);
  endtask

  task automatic t_zero_count();  // R9
    run_xfer(48'h0000_0000_0042, 16'd0, 32'h0, 1'b0, 1'b1, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    step();
    rst_n = 1;
    step();
    t_reset();
    t_lba48_three_chunks();
    t_lba28_exact_limit();
    t_lba28_one_over();
    t_lba48_wide_addr_hold();
    t_stray_request();
    t_zero_count();
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule